// File: doc/BRIEF.md
# Packed Sample FIFO for a Current-Output DAC

This block sits between a 32-bit register write path and a current-output converter. Each bus write of sample data is split into one, two or four samples, depending on a format code. Each sample is placed right- or left-justified inside a 16-bit word and appended to a four-deep queue. Each update pulse removes the oldest word and presents it as the converter code. The code then stays the same until the next successful removal.

The block reports how many words are queued. It keeps three sticky event flags: overrun, underrun and went-empty. Software can clear or force each flag. A per-flag enable decides whether that flag raises the interrupt line. A clear pulse empties the queue. In wrap mode, a removed word is appended again at the tail in the same cycle, so the queued pattern repeats for as long as update pulses arrive.

Top module: `sample_fifo_packer`

## Requirements
- R1: Format code 0 (and the unused code 3) stores one sample taken from write bits 9:0.
- R2: Format code 1 stores two 10-bit samples, bits 9:0 first and then bits 25:16.
- R3: Format code 2 stores four 8-bit samples, byte 0 first and byte 3 last.
- R4: With the justify input low, a sample is zero-extended into the low bits of the 16-bit word. With it high, the sample is shifted so that its top bit lands on bit 15, and the bits below the sample are zero.
- R5: An update pulse with a non-empty queue moves the oldest word to the code output on the next clock edge. The level output always shows the number of queued words, from 0 to 4.
- R6: If a write does not fit, the whole write is dropped and the overrun flag (status bit 0) sets. The free space counts a word that is removed in the same cycle when wrap mode is off.
- R7: An update pulse with an empty queue leaves the code output unchanged and sets the underrun flag (status bit 1).
- R8: The went-empty flag (status bit 2) sets when a removal leaves the queue empty, with no write accepted in that cycle.
- R9: A clear pulse empties the queue on the next edge. A write or update pulse in the same cycle is ignored: it changes neither the code nor any flag.
- R10: In wrap mode, a removed word is appended at the tail in the same cycle, so the level does not change. The words of a write accepted in that cycle follow the recycled word.
- R11: A status write loads each flag from the matching bit of the written value. A hardware event in the same cycle sets its flag regardless of the written value.
- R12: The interrupt output is high exactly when at least one flag is set and its enable bit (same bit order as the status) is high.
- R13: After reset, the level, code, flags and interrupt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Sample data write strobe |
| wr_data | input | 32 | Packed sample data |
| fmt | input | 2 | Unpack format code |
| left_just | input | 1 | Left-justify samples when high |
| wrap_en | input | 1 | Recirculate removed words |
| buf_clr | input | 1 | Empty the queue |
| upd | input | 1 | Update pulse, removes one word |
| stat_wr | input | 1 | Status flag write strobe |
| stat_wdata | input | 3 | Flag values: bit 0 overrun, bit 1 underrun, bit 2 went-empty |
| irq_en | input | 3 | Interrupt enables, same bit order |
| level | output | 3 | Number of queued words |
| dac_code | output | 16 | Current converter code |
| flags | output | 3 | Sticky flags, same bit order |
| irq | output | 1 | Interrupt request |

## Verification
Several cases are driven in the same cycle on purpose:
- a software status write that clears a flag while hardware raises it, for example clearing underrun during an update pulse on an empty queue;
- a write that fills the last slots while an update pulse frees one;
- a clear pulse together with a write and an update pulse.

A behavioural queue model in the bench defines the result of each collision: the hardware set wins, the freed slot counts, and the clear cancels everything else. The model is compared against the outputs after every edge, both in directed sequences and in a long random sequence that makes such collisions frequent.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    typedef enum logic [1:0] {
        FMT_ONE10  = 2'd0,
        FMT_TWO10  = 2'd1,
        FMT_FOUR8  = 2'd2,
        FMT_RSVD   = 2'd3
    } fmt_e;

    // bit 0 overrun, bit 1 underrun, bit 2 went-empty
    typedef struct packed {
        logic wemp;
        logic und;
        logic ovr;
    } flags_t;

endpackage

// File: rtl/sfp_unpack.sv
module sfp_unpack #(
    parameter int ENTRY_W = 16,
    parameter int LANES   = 4,
    localparam int NW     = $clog2(LANES + 1)
) (
    input  logic [31:0]                    wr_data,
    input  logic [1:0]                     fmt,
    input  logic                           left_just,
    output logic [NW-1:0]                  n_samples,
    output logic [LANES-1:0][ENTRY_W-1:0]  lanes
);
    import sfp_pkg::*;

    logic [LANES-1:0][ENTRY_W-1:0] raw;
    int                            samp_w;

    always_comb begin
        raw       = '0;
        n_samples = NW'(1);
        samp_w    = 10;
        case (fmt_e'(fmt))
            FMT_TWO10: begin
                n_samples = NW'(2);
                raw[0]    = {{(ENTRY_W-10){1'b0}}, wr_data[9:0]};
                raw[1]    = {{(ENTRY_W-10){1'b0}}, wr_data[25:16]};
            end
            FMT_FOUR8: begin
                n_samples = NW'(4);
                samp_w    = 8;
                for (int i = 0; i < 4; i++) begin
                    raw[i] = {{(ENTRY_W-8){1'b0}}, wr_data[8*i +: 8]};
                end
            end
            default: begin
                raw[0] = {{(ENTRY_W-10){1'b0}}, wr_data[9:0]};
            end
        endcase
        for (int i = 0; i < LANES; i++) begin
            lanes[i] = left_just ? (raw[i] << (ENTRY_W - samp_w)) : raw[i];
        end
    end

endmodule

// File: rtl/sfp_queue.sv
module sfp_queue #(
    parameter int ENTRY_W = 16,
    parameter int DEPTH   = 4,
    parameter int LANES   = 4,
    localparam int NW     = $clog2(LANES + 1),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push_req,
    input  logic [NW-1:0]                  push_n,
    input  logic [LANES-1:0][ENTRY_W-1:0]  push_lanes,
    input  logic                           pop_req,
    input  logic                           wrap,
    output logic [CNT_W-1:0]               level,
    output logic [ENTRY_W-1:0]             code,
    output logic                           ovr_evt,
    output logic                           und_evt,
    output logic                           wemp_evt
);

    typedef struct packed {
        logic [DEPTH-1:0][ENTRY_W-1:0] mem;
        logic [PTR_W-1:0]              rd;
        logic [CNT_W-1:0]              cnt;
        logic [ENTRY_W-1:0]            code;
    } q_state_t;

    q_state_t st_d, st_q;
    logic     pop_fire;
    logic     push_fire;
    int       free_slots;
    int       base;
    int       idx;

    always_comb begin
        st_d      = st_q;
        pop_fire  = pop_req && (st_q.cnt != '0) && !clr;
        free_slots = DEPTH - int'(st_q.cnt) + ((pop_fire && !wrap) ? 1 : 0);
        push_fire = push_req && !clr && (int'(push_n) <= free_slots);
        ovr_evt   = push_req && !clr && (int'(push_n) > free_slots);
        und_evt   = pop_req && !clr && (st_q.cnt == '0);
        wemp_evt  = 1'b0;
        base      = int'(st_q.rd) + int'(st_q.cnt) + ((pop_fire && wrap) ? 1 : 0);
        idx       = 0;
        if (clr) begin
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (pop_fire) begin
                st_d.code = st_q.mem[st_q.rd];
                st_d.rd   = PTR_W'((int'(st_q.rd) + 1) % DEPTH);
                if (wrap) begin
                    idx = (int'(st_q.rd) + int'(st_q.cnt)) % DEPTH;
                    st_d.mem[idx] = st_q.mem[st_q.rd];
                end
            end
            if (push_fire) begin
                for (int i = 0; i < LANES; i++) begin
                    if (i < int'(push_n)) begin
                        idx = (base + i) % DEPTH;
                        st_d.mem[idx] = push_lanes[i];
                    end
                end
            end
            st_d.cnt = CNT_W'(int'(st_q.cnt)
                              - ((pop_fire && !wrap) ? 1 : 0)
                              + (push_fire ? int'(push_n) : 0));
            wemp_evt = pop_fire && !wrap && !push_fire && (st_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.cnt;
    assign code  = st_q.code;

    // R5: level never exceeds the depth
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R9: a clear pulse leaves the queue empty
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));

    // R6: a dropped write adds nothing
    a_r6_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && !pop_fire) |=> (st_q.cnt == $past(st_q.cnt)));

    // R7: an empty update leaves the code alone
    a_r7_underrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
        und_evt |=> $stable(st_q.code));

    // R10: a recycled removal keeps the level
    a_r10_wrap_level: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_fire && wrap && !push_fire) |=> $stable(st_q.cnt));

endmodule

// File: rtl/sfp_flags.sv
module sfp_flags (
    input  logic            clk,
    input  logic            rst_n,
    input  sfp_pkg::flags_t evt,
    input  logic            sw_wr,
    input  sfp_pkg::flags_t sw_val,
    input  sfp_pkg::flags_t ie,
    output sfp_pkg::flags_t flags,
    output logic            irq
);
    import sfp_pkg::*;

    typedef struct packed {
        flags_t f;
    } fl_state_t;

    fl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_wr) begin
            st_d.f = sw_val;
        end
        st_d.f = st_d.f | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.f;
    assign irq   = |(st_q.f & ie);

    // R11: a hardware event wins over a same-cycle software clear
    a_r11_ovr_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt.ovr |=> flags.ovr);
    a_r11_und_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt.und |=> flags.und);
    // R8: the went-empty event leaves its flag set
    a_r8_wemp_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt.wemp |=> flags.wemp);
    // R11: without write or event a flag keeps its value
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && evt == '0) |=> $stable(flags));

endmodule

// File: rtl/sample_fifo_packer.sv
module sample_fifo_packer #(
    parameter int ENTRY_W = 16,
    parameter int DEPTH   = 4,
    localparam int LANES  = 4,
    localparam int NW     = $clog2(LANES + 1),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    input  logic [1:0]         fmt,
    input  logic               left_just,
    input  logic               wrap_en,
    input  logic               buf_clr,
    input  logic               upd,
    input  logic               stat_wr,
    input  logic [2:0]         stat_wdata,
    input  logic [2:0]         irq_en,
    output logic [CNT_W-1:0]   level,
    output logic [ENTRY_W-1:0] dac_code,
    output logic [2:0]         flags,
    output logic               irq
);
    import sfp_pkg::*;

    logic [NW-1:0]                 n_samples;
    logic [LANES-1:0][ENTRY_W-1:0] lanes;
    logic                          ovr_evt, und_evt, wemp_evt;
    flags_t                        evt, fl;

    sfp_unpack #(.ENTRY_W(ENTRY_W), .LANES(LANES)) u_unpack (
        .wr_data   (wr_data),
        .fmt       (fmt),
        .left_just (left_just),
        .n_samples (n_samples),
        .lanes     (lanes)
    );

    sfp_queue #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .LANES(LANES)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (buf_clr),
        .push_req   (wr_en),
        .push_n     (n_samples),
        .push_lanes (lanes),
        .pop_req    (upd),
        .wrap       (wrap_en),
        .level      (level),
        .code       (dac_code),
        .ovr_evt    (ovr_evt),
        .und_evt    (und_evt),
        .wemp_evt   (wemp_evt)
    );

    assign evt = '{wemp: wemp_evt, und: und_evt, ovr: ovr_evt};

    sfp_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .sw_wr  (stat_wr),
        .sw_val (flags_t'(stat_wdata)),
        .ie     (flags_t'(irq_en)),
        .flags  (fl),
        .irq    (irq)
    );

    assign flags = fl;

endmodule

// File: tb/tb_sample_fifo_packer.sv
`timescale 1ns/1ps
module tb_sample_fifo_packer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, left_just, wrap_en, buf_clr, upd, stat_wr;
    logic [31:0] wr_data;
    logic [1:0]  fmt;
    logic [2:0]  stat_wdata, irq_en;
    logic [2:0]  level;
    logic [15:0] dac_code;
    logic [2:0]  flags;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    logic [15:0] mq[$];
    logic [15:0] m_code;
    logic [2:0]  m_flags;

    always #10 clk = ~clk;

    sample_fifo_packer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fmt(fmt),
        .left_just(left_just), .wrap_en(wrap_en), .buf_clr(buf_clr), .upd(upd),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_en(irq_en),
        .level(level), .dac_code(dac_code), .flags(flags), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int unpack(input logic [31:0] d, input logic [1:0] f, input bit l,
                                  output logic [15:0] s[4]);
        int n, w;
        for (int i = 0; i < 4; i++) s[i] = 16'h0;
        if (f == 2'd1) begin
            n = 2; w = 10; s[0] = 16'(d[9:0]); s[1] = 16'(d[25:16]);
        end else if (f == 2'd2) begin
            n = 4; w = 8;
            for (int i = 0; i < 4; i++) s[i] = 16'(d[8*i +: 8]);
        end else begin
            n = 1; w = 10; s[0] = 16'(d[9:0]);
        end
        if (l) for (int i = 0; i < 4; i++) s[i] = s[i] << (16 - w);
        return n;
    endfunction

    task automatic step(input string tag);
        logic [15:0] s[4];
        int n, free;
        bit pop, ovr, und, wemp, acc;
        logic [15:0] head;
        logic [2:0] nf;
        n = unpack(wr_data, fmt, left_just, s);
        ovr = 0; und = 0; wemp = 0; acc = 0;
        if (buf_clr) begin
            mq.delete();
        end else begin
            pop  = upd && mq.size() > 0;
            und  = upd && mq.size() == 0;
            free = 4 - mq.size() + ((pop && !wrap_en) ? 1 : 0);
            acc  = wr_en && n <= free;
            ovr  = wr_en && n > free;
            if (pop) begin
                head = mq.pop_front();
                m_code = head;
                if (wrap_en) mq.push_back(head);
            end
            if (acc) for (int i = 0; i < n; i++) mq.push_back(s[i]);
            wemp = pop && !wrap_en && !acc && mq.size() == 0;
        end
        nf = stat_wr ? stat_wdata : m_flags;
        m_flags = nf | {wemp, und, ovr};
        @(posedge clk);
        #1;
        chk(level == 3'(mq.size()), tag, "level", 32'(level), 32'(mq.size()));
        chk(dac_code == m_code, tag, "code", 32'(dac_code), 32'(m_code));
        chk(flags == m_flags, tag, "flags", 32'(flags), 32'(m_flags));
        chk(irq == |(m_flags & irq_en), tag, "irq", 32'(irq), 32'(|(m_flags & irq_en)));
        wr_en = 0; upd = 0; buf_clr = 0; stat_wr = 0;
    endtask

    task automatic wr(input logic [31:0] d, input logic [1:0] f, input bit l, input string tag);
        wr_en = 1; wr_data = d; fmt = f; left_just = l;
        step(tag);
    endtask

    task automatic up(input string tag);
        upd = 1;
        step(tag);
    endtask

    initial begin
        #4_000_000;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_data = 0; fmt = 0; left_just = 0; wrap_en = 0;
        buf_clr = 0; upd = 0; stat_wr = 0; stat_wdata = 0; irq_en = 0;
        m_code = 0; m_flags = 0;
        repeat (3) @(posedge clk);
        #5 rst_n = 1;
        #1;
        // R13: reset state
        chk(level == 0, "R13", "level", 32'(level), 0);
        chk(dac_code == 0, "R13", "code", 32'(dac_code), 0);
        chk(flags == 0, "R13", "flags", 32'(flags), 0);
        chk(irq == 0, "R13", "irq", 32'(irq), 0);

        // R1 and R4: one 10-bit sample, both justifications
        wr(32'hFFFF_F3A5, 2'd0, 0, "R1");
        up("R5");
        wr(32'h0000_02C1, 2'd0, 1, "R4");
        up("R4");
        wr(32'h0000_0155, 2'd3, 0, "R1");
        up("R1");
        // R2: two samples
        wr(32'h0155_02AA, 2'd1, 0, "R2");
        up("R2"); up("R2");
        wr(32'h03FF_0001, 2'd1, 1, "R4");
        up("R4"); up("R4");
        // R3: four bytes
        wr(32'h4433_2211, 2'd2, 1, "R3");
        repeat (4) up("R3");
        wr(32'h8877_6655, 2'd2, 0, "R3");
        // R6: full queue rejects, freed slot counts
        wr(32'h0000_0123, 2'd0, 0, "R6");
        upd = 1; wr(32'h0000_0321, 2'd0, 0, "R6");
        upd = 1; wr(32'h0001_0002, 2'd1, 0, "R6");
        // R8 and R7: drain and overdrain
        repeat (4) up("R8");
        up("R7"); up("R7");
        // R11: clear, collision with event, force
        stat_wr = 1; stat_wdata = 3'b000; step("R11");
        upd = 1; stat_wr = 1; stat_wdata = 3'b000; step("R11");
        stat_wr = 1; stat_wdata = 3'b100; step("R11");
        // R12: enables
        irq_en = 3'b010; step("R12");
        irq_en = 3'b001; step("R12");
        irq_en = 3'b110; step("R12");
        stat_wr = 1; stat_wdata = 3'b000; step("R12");
        // R9: clear with write and update
        wr(32'h1234_5678, 2'd2, 0, "R9");
        buf_clr = 1; upd = 1; wr(32'h0000_0099, 2'd0, 0, "R9");
        up("R9");
        // R10: wrap mode recirculates
        wr(32'h0002_0001, 2'd1, 0, "R10");
        wr(32'h0000_0003, 2'd0, 0, "R10");
        wrap_en = 1;
        repeat (7) up("R10");
        upd = 1; wr(32'h0000_0004, 2'd0, 0, "R10");
        repeat (5) up("R10");
        upd = 1; wr(32'h0000_0005, 2'd0, 0, "R10");
        wrap_en = 0;
        repeat (5) up("R10");

        // random mix of everything
        for (int k = 0; k < 3000; k++) begin
            wr_en      = ($urandom % 3) == 0;
            wr_data    = $urandom;
            fmt        = 2'($urandom % 4);
            left_just  = 1'($urandom);
            upd        = ($urandom % 2) == 0;
            buf_clr    = ($urandom % 29) == 0;
            stat_wr    = ($urandom % 11) == 0;
            stat_wdata = 3'($urandom);
            if (($urandom % 50) == 0) wrap_en = ~wrap_en;
            if (($urandom % 40) == 0) irq_en = 3'($urandom);
            step("R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule